// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Engine

This block moves bytes from one peripheral data register into a block of memory without the processor doing the copying. The peripheral raises a request line each time it has a byte ready. When the channel is armed, the engine asks the processor for the bus with a hold output and waits for the grant input. While it holds the grant it reads one byte from the peripheral address and then writes that byte to the current memory address. After the write it hands the bus back.

Software sets the channel up through a small write-only register port. It loads the memory start address, the peripheral address and the number of bytes, then sets the enable bit. After each byte the engine steps its memory pointer up by one and its remaining count down by one. When the count runs out the engine disarms itself and raises an interrupt. The interrupt stays high until software clears it. The address, data and strobe drivers each have an output enable of their own, so the chip's tristate pads never fight the processor during a change of bus ownership.

Top module: `dma_xfer_top`

## Requirements
- R1: After reset, hold is low, every output enable (addr_oe, strb_oe, data_oe) is low, rd_n and wr_n are high and irq is low.
- R2: A request is accepted only when all of these hold: dreq is high, the channel is enabled, the remaining count is nonzero and hlda is low. Hold rises on the next clock. No read or write strobe is issued until hlda has been sampled high.
- R3: addr_oe, strb_oe and data_oe are only ever high while hlda is high. They turn on in the cycle after hlda is first sampled high.
- R4: When a transfer ends, all output enables go low for one cycle while hold is still high. Hold falls on the next clock.
- R5: The read cycle drives the peripheral address on addr_o for three cycles: setup, strobe and hold. rd_n is low for exactly the middle cycle, and the byte on data_i is captured at the end of that cycle.
- R6: The write cycle follows the read cycle directly. It drives the memory address on addr_o and the captured byte on data_o (data_oe high) for three cycles, with wr_n low for exactly the middle one. rd_n and wr_n are never low together.
- R7: After each completed write the memory address goes up by one, so that successive bytes land in successive locations starting at the programmed start address.
- R8: After each byte the count goes down by one. When it reaches zero the enable bit clears and irq rises. irq then stays high until a write to control offset 3 with bit 1 set.
- R9: While the channel is disabled or the count is zero, requests start no bus activity: hold stays low.
- R10: A request held high through a transfer is taken again only after that transfer has finished and hlda has been sampled low.
- R11: Register offsets on reg_addr are 0 for memory start address, 1 for peripheral address, 2 for byte count and 3 for control. In the control register, bit 0 is enable, and writing 1 to bit 1 clears the done/irq flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| dreq | input | 1 | Peripheral byte-ready request |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| addr_o | output | 16 | Bus address |
| addr_oe | output | 1 | Address driver enable |
| data_i | input | 8 | Bus read data |
| data_o | output | 8 | Bus write data |
| data_oe | output | 1 | Data driver enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| strb_oe | output | 1 | Strobe driver enable |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench models the processor granting the bus one cycle after hold and dropping the grant one cycle after hold falls. Against that model it looks hardest at ownership edges. A design that enabled its drivers on the hold edge, or dropped hold in the same cycle as its enables, would show a driver active without grant or a hold fall with enables still high. A request held high across a whole transfer checks that the engine waits for the grant to fall. A design that did not wait would raise hold early, or would fill memory with fewer or duplicated bytes. The last byte, the dreq still held after the block is done, a disabled channel and a zero count together catch an off-by-one terminal count, a missing auto-disable, or an interrupt that clears itself instead of waiting for the clear write.

// File: rtl/dma_pkg.sv
// Shared types for the DMA engine: transfer sequencer states and register offsets.
package dma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // bus released, waiting for an accepted request
        ST_REQ,     // hold raised, waiting for grant
        ST_RSET,    // read address setup
        ST_RSTB,    // read strobe
        ST_RHLD,    // read address hold
        ST_WSET,    // write address/data setup
        ST_WSTB,    // write strobe
        ST_WHLD,    // write address/data hold
        ST_REL      // drivers off, hold still high
    } dma_st_e;

    localparam logic [1:0] OFS_MEM  = 2'd0;
    localparam logic [1:0] OFS_PER  = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;
    localparam logic [1:0] OFS_CTRL = 2'd3;

endpackage

// File: rtl/dma_regs.sv
// Channel register file and transfer counters.
// Assumes software does not write while a transfer is in flight; a write in
// the same cycle as a step takes priority over the step result.
module dma_regs #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    ofs,
    input  logic [RW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] per_addr,
    output logic          armed,
    output logic          done
);
    import dma_pkg::*;

    logic [CW-1:0] cnt_q;
    logic          en_q;

    // Counter advance on each finished byte, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            per_addr <= '0;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (step) begin
                mem_addr <= mem_addr + AW'(1);
                cnt_q    <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    en_q <= 1'b0;
                    done <= 1'b1;
                end
            end
            if (we) begin
                case (ofs)
                    OFS_MEM:  mem_addr <= wdata[AW-1:0];
                    OFS_PER:  per_addr <= wdata[AW-1:0];
                    OFS_CNT:  cnt_q    <= wdata[CW-1:0];
                    default: begin
                        en_q <= wdata[0];
                        if (wdata[1]) done <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Channel may accept a request only when enabled with bytes left.
    assign armed = en_q && (cnt_q != '0);

endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: hold/grant handshake and the fixed read-then-write
// strobe pattern. Assumes the grant stays high while hold is high.
module dma_seq (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dreq,
    input  logic              hlda,
    input  logic              armed,
    output dma_pkg::dma_st_e  st,
    output logic              step
);
    import dma_pkg::*;

    dma_st_e st_nx;

    // Next-state selection.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (dreq && armed && !hlda) st_nx = ST_REQ;
            ST_REQ:  if (hlda) st_nx = ST_RSET;
            ST_RSET: st_nx = ST_RSTB;
            ST_RSTB: st_nx = ST_RHLD;
            ST_RHLD: st_nx = ST_WSET;
            ST_WSET: st_nx = ST_WSTB;
            ST_WSTB: st_nx = ST_WHLD;
            ST_WHLD: st_nx = ST_REL;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // One pulse per byte, on the last write cycle.
    assign step = (st == ST_WHLD);

endmodule

// File: rtl/dma_bus.sv
// Bus-side datapath: decodes sequencer state into hold, output enables,
// strobes and address, and holds the byte captured from the peripheral.
module dma_bus #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_pkg::dma_st_e  st,
    input  logic [AW-1:0]     mem_addr,
    input  logic [AW-1:0]     per_addr,
    input  logic [DW-1:0]     data_i,
    output logic              hold,
    output logic [AW-1:0]     addr_o,
    output logic              addr_oe,
    output logic [DW-1:0]     data_o,
    output logic              data_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              strb_oe
);
    import dma_pkg::*;

    logic rd_phase;
    logic wr_phase;

    // Phase decode from the registered state.
    always_comb begin
        rd_phase = (st == ST_RSET) || (st == ST_RSTB) || (st == ST_RHLD);
        wr_phase = (st == ST_WSET) || (st == ST_WSTB) || (st == ST_WHLD);
    end

    // Capture the peripheral byte at the end of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              data_o <= '0;
        else if (st == ST_RSTB)  data_o <= data_i;
    end

    assign hold    = (st != ST_IDLE);
    assign addr_oe = rd_phase || wr_phase;
    assign strb_oe = rd_phase || wr_phase;
    assign data_oe = wr_phase;
    assign addr_o  = wr_phase ? mem_addr : per_addr;
    assign rd_n    = (st != ST_RSTB);
    assign wr_n    = (st != ST_WSTB);

endmodule

// File: rtl/dma_xfer_top.sv
// Single-channel peripheral-to-memory DMA engine top level.
// Assumes the processor keeps hlda high for as long as hold is high.
module dma_xfer_top #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    input  logic          dreq,
    output logic          hold,
    input  logic          hlda,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          strb_oe,
    output logic          irq
);
    import dma_pkg::*;

    logic [AW-1:0] mem_addr;
    logic [AW-1:0] per_addr;
    logic          armed;
    logic          step;
    dma_st_e       st;

    dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .ofs(reg_addr),
        .wdata(reg_wdata), .step(step), .mem_addr(mem_addr),
        .per_addr(per_addr), .armed(armed), .done(irq)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .hlda(hlda),
        .armed(armed), .st(st), .step(step)
    );

    dma_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .st(st), .mem_addr(mem_addr),
        .per_addr(per_addr), .data_i(data_i), .hold(hold),
        .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o),
        .data_oe(data_oe), .rd_n(rd_n), .wr_n(wr_n), .strb_oe(strb_oe)
    );

endmodule

// File: rtl/dma_xfer_chk.sv
// Port-level protocol checks for dma_xfer_top, attached by bind.
module dma_xfer_chk #(
    parameter int AW = 16,
    localparam int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [RW-1:0] reg_wdata,
    input logic          hold,
    input logic          hlda,
    input logic [AW-1:0] addr_o,
    input logic          addr_oe,
    input logic          data_oe,
    input logic          rd_n,
    input logic          wr_n,
    input logic          strb_oe,
    input logic          irq
);
    // R2
    no_strobe_before_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda |-> (rd_n && wr_n));

    // R3
    drivers_need_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe || strb_oe || data_oe) |-> hlda);

    // R4
    hold_drop_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(!addr_oe && !strb_oe && !data_oe && hold));

    // R5
    rd_addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (addr_oe && $past(addr_oe) && $stable(addr_o)));

    // R5
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> (rd_n && addr_oe && $stable(addr_o)));

    // R6
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_n && data_oe && $stable(addr_o)));

    // R6
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_addr == 2'd3 && reg_wdata[1])) |=> irq);

    // R10
    hold_needs_low_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(!hlda));

endmodule

bind dma_xfer_top dma_xfer_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dma_xfer_top.sv
module sim_dma_xfer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        dreq = 1'b0;
    logic        hold;
    logic        hlda = 1'b0;
    logic [15:0] addr_o;
    logic        addr_oe;
    logic [7:0]  data_i;
    logic [7:0]  data_o;
    logic        data_oe;
    logic        rd_n;
    logic        wr_n;
    logic        strb_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] pbyte = 8'h00;
    logic [7:0] mem [logic [15:0]];
    int rises = 0;

    // reference model state
    int          ph = 0;
    logic        m_en = 0, m_done = 0;
    logic [15:0] m_mem = 0, m_per = 0, m_cnt = 0;
    logic [7:0]  m_byte = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_xfer_top u0 (.*);

    assign data_i = rd_n ? 8'h00 : pbyte;

    // processor grant model and bus observers
    always @(posedge clk) begin
        if (!rst_n) hlda <= 1'b0;
        else        hlda <= hold;
        if (!rd_n) pbyte <= pbyte + 8'd1;
        if (rst_n && !wr_n && strb_oe) mem[addr_o] = data_o;
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_en = 0; m_done = 0; m_mem = 0; m_per = 0; m_cnt = 0; m_byte = 0;
        end else begin
            if (ph == 0) begin
                if (dreq && m_en && m_cnt != 0 && !hlda) ph = 1;
            end else if (ph == 1) begin
                if (hlda) ph = 2;
            end else if (ph == 8) begin
                ph = 0;
            end else begin
                if (ph == 3) m_byte = pbyte;
                if (ph == 7) begin
                    m_mem = m_mem + 1;
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin m_en = 0; m_done = 1; end
                end
                ph = ph + 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_mem = reg_wdata;
                    2'd1: m_per = reg_wdata;
                    2'd2: m_cnt = reg_wdata;
                    default: begin
                        m_en = reg_wdata[0];
                        if (reg_wdata[1]) m_done = 0;
                    end
                endcase
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_aoe, e_doe;
            e_aoe = (ph >= 2 && ph <= 7);
            e_doe = (ph >= 5 && ph <= 7);
            chk(hold === (ph != 0), "R2/R4 hold", 32'(hold), 32'(ph != 0));
            chk(addr_oe === e_aoe && strb_oe === e_aoe, "R3 addr/strobe enable", 32'({addr_oe, strb_oe}), 32'({e_aoe, e_aoe}));
            chk(data_oe === e_doe, "R6 data enable", 32'(data_oe), 32'(e_doe));
            chk(rd_n === (ph != 3), "R5 rd_n", 32'(rd_n), 32'(ph != 3));
            chk(wr_n === (ph != 6), "R6 wr_n", 32'(wr_n), 32'(ph != 6));
            chk(irq === m_done, "R8 irq", 32'(irq), 32'(m_done));
            if (e_aoe) chk(addr_o === ((ph < 5) ? m_per : m_mem), "R5/R7 addr", 32'(addr_o), 32'((ph < 5) ? m_per : m_mem));
            if (e_doe) chk(data_o === m_byte, "R6 data_o", 32'(data_o), 32'(m_byte));
        end
    end

    always @(posedge clk) if (rst_n && hold && !$past(hold)) rises++;

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic mem_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
        if (mem.exists(a)) chk(mem[a] === exp, req, 32'(mem[a]), 32'(exp));
        else               chk(1'b0, req, 32'hdead, 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!hold && !addr_oe && !strb_oe && !data_oe && rd_n && wr_n && !irq, "R1 reset outputs",
            32'({hold, addr_oe, strb_oe, data_oe, rd_n, wr_n, irq}), 32'b0000110);

        // R11 programming, R2/R5/R6/R7 block of three
        pbyte = 8'hA1;
        wreg(2'd0, 16'h1000);
        wreg(2'd1, 16'h00F0);
        wreg(2'd2, 16'd3);
        wreg(2'd3, 16'h0001);
        pulse_req();
        pulse_req();
        @(negedge clk); dreq = 1'b1;       // held through and beyond the last byte
        repeat (40) @(negedge clk);
        // R9 held request after completion is ignored
        chk(!hold, "R9 no hold after block done", 32'(hold), 0);
        dreq = 1'b0;
        mem_chk(16'h1000, 8'hA1, "R7 byte0");
        mem_chk(16'h1001, 8'hA2, "R7 byte1");
        mem_chk(16'h1002, 8'hA3, "R7 byte2");
        chk(!mem.exists(16'h1003), "R8 stop at count", 32'(mem.exists(16'h1003)), 0);
        chk(irq, "R8 irq sticky", 32'(irq), 1);
        wreg(2'd3, 16'h0002);
        @(negedge clk);
        chk(!irq, "R8 irq cleared", 32'(irq), 0);

        // R9 disabled channel and zero count
        wreg(2'd2, 16'd2);
        pulse_req();
        chk(!hold && rises == 3, "R9 disabled ignore", 32'(rises), 3);
        wreg(2'd2, 16'd0);
        wreg(2'd3, 16'h0001);
        pulse_req();
        chk(rises == 3, "R9 zero count ignore", 32'(rises), 3);

        // R10 request held high across back-to-back transfers
        pbyte = 8'h50;
        wreg(2'd0, 16'h2000);
        wreg(2'd2, 16'd3);
        wreg(2'd3, 16'h0001);
        @(negedge clk); dreq = 1'b1;
        repeat (60) @(negedge clk);
        dreq = 1'b0;
        chk(rises == 6, "R10 one hold per byte", 32'(rises), 6);
        mem_chk(16'h2000, 8'h50, "R10 byte0");
        mem_chk(16'h2001, 8'h51, "R10 byte1");
        mem_chk(16'h2002, 8'h52, "R10 byte2");
        chk(irq, "R8 irq second block", 32'(irq), 1);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule